// File: doc/BRIEF.md
# Shared-Pin Port and Link Multiplexer

This block arbitrates a bank of general-purpose I/O pins among several overlapping functions: a set of 1-bit ports, 4-bit, 8-bit and 16-bit port groups, one 32-bit port, and a serial link. Each function can be switched on independently. Each port has a direction that applies to every one of its pins. The block decides, for every pin on its own, which function owns it. The owner drives the pin's output-enable and output value, or has the pin's input value routed back to it.

Ownership follows a fixed ranking. An enabled link beats all ports. Among ports, a narrower enabled port beats a wider one. A wider port still owns every pin that no higher-ranked function claims, so enabling a narrow port takes away only the pins it sits on. Every port's data bus always keeps its full width. The enable and direction settings are registered, so ownership follows the settings one clock after they are presented, while write and read data pass through without delay.

Top module: `shared_pin_mux`

## Requirements
- R1: After reset every port and the link are disabled: all `pin_oe` bits are 0 and every read bus (`p1_rdata`, `p4_rdata`, `p8_rdata`, `p16_rdata`, `p32_rdata`, `link_rx`) is 0.
- R2: Enable, direction and link-mode inputs are captured on the rising clock edge, so a change is visible at the pins only after the next edge and not before it.
- R3: With the link enabled in wide mode (`link_wide`=1) it owns pins 8..12 as inputs (lane i on pin 8+i, returned on `link_rx[i]`) and pins 13..17 as outputs (lane i on pin 13+i, driven high-enable from `link_tx[i]`); no port sees those pins.
- R4: With the link enabled in narrow mode (`link_wide`=0) it owns only pins 8, 9 (input lanes 0, 1) and 13, 14 (output lanes 0, 1); `link_rx[4:2]` read 0 and pins 10..12 and 15..17 stay available to ports.
- R5: Per pin the ranking is link, then 1-bit port, 4-bit, 8-bit, 16-bit, 32-bit. 1-bit port k sits on pin 4k; 4-bit port k on pins 4k..4k+3; 8-bit port k on pins 8k..8k+7; 16-bit port k on pins 16k..16k+15; the 32-bit port on pins 0..31.
- R6: A wider port keeps every pin that no higher-ranked enabled function claims.
- R7: Bits of a port whose pins are owned by another function read as 0, and values written to those bits do not reach any pin. Bit j of the 4-, 8-, 16- and 32-bit write and read buses maps to pin j.
- R8: A port's direction bit (1 = output) applies to all pins it owns: as output it drives `pin_oe`=1 and `pin_out` from its write data, and its read bits are 0; as input it leaves `pin_oe`=0 and reads the pin value.
- R9: A pin owned by no function has `pin_oe`=0, and `pin_out` is 0 on every pin whose `pin_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_en | input | 1 | Link enable |
| link_wide | input | 1 | Link mode: 1 = five lanes each way, 0 = two lanes each way |
| link_tx | input | 5 | Link transmit lanes |
| link_rx | output | 5 | Link receive lanes |
| p1_en | input | 8 | Enables of the 1-bit ports |
| p1_dir | input | 8 | Directions of the 1-bit ports (1 = output) |
| p1_wdata | input | 8 | Write data of the 1-bit ports |
| p1_rdata | output | 8 | Read data of the 1-bit ports |
| p4_en | input | 8 | Enables of the 4-bit ports |
| p4_dir | input | 8 | Directions of the 4-bit ports |
| p4_wdata | input | 32 | Write data of the 4-bit ports, bit j to pin j |
| p4_rdata | output | 32 | Read data of the 4-bit ports, bit j from pin j |
| p8_en | input | 4 | Enables of the 8-bit ports |
| p8_dir | input | 4 | Directions of the 8-bit ports |
| p8_wdata | input | 32 | Write data of the 8-bit ports |
| p8_rdata | output | 32 | Read data of the 8-bit ports |
| p16_en | input | 2 | Enables of the 16-bit ports |
| p16_dir | input | 2 | Directions of the 16-bit ports |
| p16_wdata | input | 32 | Write data of the 16-bit ports |
| p16_rdata | output | 32 | Read data of the 16-bit ports |
| p32_en | input | 1 | Enable of the 32-bit port |
| p32_dir | input | 1 | Direction of the 32-bit port |
| p32_wdata | input | 32 | Write data of the 32-bit port |
| p32_rdata | output | 32 | Read data of the 32-bit port |
| pin_in | input | 32 | Sampled pin values |
| pin_oe | output | 32 | Per-pin output enable |
| pin_out | output | 32 | Per-pin output value |

## Verification
A wrong ownership decision shows up at once, in the same cycle as the registered settings, as a pin whose `pin_oe` or `pin_out` disagrees with the ranking, or as a read bit that is nonzero for a pin the port lost. A stuck or mis-reset configuration register shows up one edge after the settings change, or on the first cycle after reset, as output enables that do not follow the inputs. Checks therefore apply each setting, wait one edge, and compare every pin and every read bus against values worked out from the ranking.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

    parameter int PIN_COUNT   = 32;
    parameter int P1_STRIDE   = 4;
    parameter int GRP4        = 4;
    parameter int GRP8        = 8;
    parameter int GRP16       = 16;
    parameter int LINK_BASE   = 8;
    parameter int LINK_LANES  = 5;
    parameter int LINK_NARROW = 2;

    localparam int P1_COUNT  = PIN_COUNT / P1_STRIDE;
    localparam int P4_COUNT  = PIN_COUNT / GRP4;
    localparam int P8_COUNT  = PIN_COUNT / GRP8;
    localparam int P16_COUNT = PIN_COUNT / GRP16;

    // Who drives or samples a pin; order of declaration is not the ranking.
    typedef enum logic [2:0] {
        OWN_NONE,
        OWN_LINK_IN,
        OWN_LINK_OUT,
        OWN_P1,
        OWN_P4,
        OWN_P8,
        OWN_P16,
        OWN_P32
    } owner_e;

    typedef struct packed {
        owner_e owner;
        logic   drive;   // 1 when the owner uses the pin as an output
    } pin_claim_t;

    typedef struct packed {
        logic                 link_en;
        logic                 link_wide;
        logic [P1_COUNT-1:0]  p1_en;
        logic [P1_COUNT-1:0]  p1_out;
        logic [P4_COUNT-1:0]  p4_en;
        logic [P4_COUNT-1:0]  p4_out;
        logic [P8_COUNT-1:0]  p8_en;
        logic [P8_COUNT-1:0]  p8_out;
        logic [P16_COUNT-1:0] p16_en;
        logic [P16_COUNT-1:0] p16_out;
        logic                 p32_en;
        logic                 p32_out;
    } mux_cfg_t;

    // Offset of a pin inside the link window (negative when below it).
    function automatic int link_offset(int pin);
        return pin - LINK_BASE;
    endfunction

    function automatic bit in_window(int off, int lo, int count);
        return (off >= lo) && (off < lo + count);
    endfunction

endpackage

// File: rtl/pinmux_cfg_reg.sv
module pinmux_cfg_reg
    import pinmux_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  mux_cfg_t cfg_d,
    output mux_cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

endmodule

// File: rtl/pinmux_arbiter.sv
module pinmux_arbiter
    import pinmux_pkg::*;
(
    input  mux_cfg_t   cfg,
    output pin_claim_t claim [PIN_COUNT]
);

    for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
        localparam int  OFF    = link_offset(p);
        localparam bit  IN_W   = in_window(OFF, 0, LINK_LANES);
        localparam bit  IN_N   = in_window(OFF, 0, LINK_NARROW);
        localparam bit  OUT_W  = in_window(OFF, LINK_LANES, LINK_LANES);
        localparam bit  OUT_N  = in_window(OFF, LINK_LANES, LINK_NARROW);
        localparam bit  HAS_P1 = ((p % P1_STRIDE) == 0) && ((p / P1_STRIDE) < P1_COUNT);
        localparam int  P1_IDX = HAS_P1 ? (p / P1_STRIDE) : 0;
        localparam int  P4_IDX = p / GRP4;
        localparam int  P8_IDX = p / GRP8;
        localparam int  P16_IDX = p / GRP16;

        pin_claim_t pick;

        always_comb begin
            pick = '{owner: OWN_NONE, drive: 1'b0};
            if (cfg.link_en && (cfg.link_wide ? IN_W : IN_N)) begin
                pick = '{owner: OWN_LINK_IN, drive: 1'b0};
            end else if (cfg.link_en && (cfg.link_wide ? OUT_W : OUT_N)) begin
                pick = '{owner: OWN_LINK_OUT, drive: 1'b1};
            end else if (HAS_P1 && cfg.p1_en[P1_IDX]) begin
                pick = '{owner: OWN_P1, drive: cfg.p1_out[P1_IDX]};
            end else if (cfg.p4_en[P4_IDX]) begin
                pick = '{owner: OWN_P4, drive: cfg.p4_out[P4_IDX]};
            end else if (cfg.p8_en[P8_IDX]) begin
                pick = '{owner: OWN_P8, drive: cfg.p8_out[P8_IDX]};
            end else if (cfg.p16_en[P16_IDX]) begin
                pick = '{owner: OWN_P16, drive: cfg.p16_out[P16_IDX]};
            end else if (cfg.p32_en) begin
                pick = '{owner: OWN_P32, drive: cfg.p32_out};
            end
        end

        assign claim[p] = pick;
    end

endmodule

// File: rtl/pinmux_driver.sv
module pinmux_driver
    import pinmux_pkg::*;
(
    input  pin_claim_t            claim [PIN_COUNT],
    input  logic [LINK_LANES-1:0] link_tx,
    input  logic [P1_COUNT-1:0]   p1_wdata,
    input  logic [PIN_COUNT-1:0]  p4_wdata,
    input  logic [PIN_COUNT-1:0]  p8_wdata,
    input  logic [PIN_COUNT-1:0]  p16_wdata,
    input  logic [PIN_COUNT-1:0]  p32_wdata,
    output logic [PIN_COUNT-1:0]  pin_oe,
    output logic [PIN_COUNT-1:0]  pin_out
);

    for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
        localparam int OFF    = link_offset(p);
        localparam int LANE   = in_window(OFF, LINK_LANES, LINK_LANES) ? (OFF - LINK_LANES) : 0;
        localparam int P1_IDX = ((p / P1_STRIDE) < P1_COUNT) ? (p / P1_STRIDE) : 0;

        logic src;

        always_comb begin
            unique case (claim[p].owner)
                OWN_LINK_OUT: src = link_tx[LANE];
                OWN_P1:       src = p1_wdata[P1_IDX];
                OWN_P4:       src = p4_wdata[p];
                OWN_P8:       src = p8_wdata[p];
                OWN_P16:      src = p16_wdata[p];
                OWN_P32:      src = p32_wdata[p];
                default:      src = 1'b0;
            endcase
        end

        assign pin_oe[p]  = claim[p].drive;
        assign pin_out[p] = claim[p].drive & src;
    end

endmodule

// File: rtl/pinmux_router.sv
module pinmux_router
    import pinmux_pkg::*;
(
    input  pin_claim_t            claim [PIN_COUNT],
    input  logic [PIN_COUNT-1:0]  pin_in,
    output logic [LINK_LANES-1:0] link_rx,
    output logic [P1_COUNT-1:0]   p1_rdata,
    output logic [PIN_COUNT-1:0]  p4_rdata,
    output logic [PIN_COUNT-1:0]  p8_rdata,
    output logic [PIN_COUNT-1:0]  p16_rdata,
    output logic [PIN_COUNT-1:0]  p32_rdata
);

    function automatic logic sample(pin_claim_t c, owner_e who, logic v);
        return (c.owner == who) && !c.drive && v;
    endfunction

    for (genvar p = 0; p < PIN_COUNT; p++) begin : g_wide
        assign p4_rdata[p]  = sample(claim[p], OWN_P4,  pin_in[p]);
        assign p8_rdata[p]  = sample(claim[p], OWN_P8,  pin_in[p]);
        assign p16_rdata[p] = sample(claim[p], OWN_P16, pin_in[p]);
        assign p32_rdata[p] = sample(claim[p], OWN_P32, pin_in[p]);
    end

    for (genvar k = 0; k < P1_COUNT; k++) begin : g_single
        assign p1_rdata[k] = sample(claim[k*P1_STRIDE], OWN_P1, pin_in[k*P1_STRIDE]);
    end

    for (genvar i = 0; i < LINK_LANES; i++) begin : g_lane
        assign link_rx[i] = sample(claim[LINK_BASE+i], OWN_LINK_IN, pin_in[LINK_BASE+i]);
    end

endmodule

// File: rtl/shared_pin_mux.sv
module shared_pin_mux
    import pinmux_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  link_en,
    input  logic                  link_wide,
    input  logic [LINK_LANES-1:0] link_tx,
    output logic [LINK_LANES-1:0] link_rx,
    input  logic [P1_COUNT-1:0]   p1_en,
    input  logic [P1_COUNT-1:0]   p1_dir,
    input  logic [P1_COUNT-1:0]   p1_wdata,
    output logic [P1_COUNT-1:0]   p1_rdata,
    input  logic [P4_COUNT-1:0]   p4_en,
    input  logic [P4_COUNT-1:0]   p4_dir,
    input  logic [PIN_COUNT-1:0]  p4_wdata,
    output logic [PIN_COUNT-1:0]  p4_rdata,
    input  logic [P8_COUNT-1:0]   p8_en,
    input  logic [P8_COUNT-1:0]   p8_dir,
    input  logic [PIN_COUNT-1:0]  p8_wdata,
    output logic [PIN_COUNT-1:0]  p8_rdata,
    input  logic [P16_COUNT-1:0]  p16_en,
    input  logic [P16_COUNT-1:0]  p16_dir,
    input  logic [PIN_COUNT-1:0]  p16_wdata,
    output logic [PIN_COUNT-1:0]  p16_rdata,
    input  logic                  p32_en,
    input  logic                  p32_dir,
    input  logic [PIN_COUNT-1:0]  p32_wdata,
    output logic [PIN_COUNT-1:0]  p32_rdata,
    input  logic [PIN_COUNT-1:0]  pin_in,
    output logic [PIN_COUNT-1:0]  pin_oe,
    output logic [PIN_COUNT-1:0]  pin_out
);

    mux_cfg_t   cfg_d;
    mux_cfg_t   cfg_q;
    pin_claim_t claim [PIN_COUNT];

    assign cfg_d = '{
        link_en:   link_en,
        link_wide: link_wide,
        p1_en:     p1_en,
        p1_out:    p1_dir,
        p4_en:     p4_en,
        p4_out:    p4_dir,
        p8_en:     p8_en,
        p8_out:    p8_dir,
        p16_en:    p16_en,
        p16_out:   p16_dir,
        p32_en:    p32_en,
        p32_out:   p32_dir
    };

    pinmux_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .cfg_d (cfg_d),
        .cfg_q (cfg_q)
    );

    pinmux_arbiter u_arb (
        .cfg   (cfg_q),
        .claim (claim)
    );

    pinmux_driver u_drv (
        .claim     (claim),
        .link_tx   (link_tx),
        .p1_wdata  (p1_wdata),
        .p4_wdata  (p4_wdata),
        .p8_wdata  (p8_wdata),
        .p16_wdata (p16_wdata),
        .p32_wdata (p32_wdata),
        .pin_oe    (pin_oe),
        .pin_out   (pin_out)
    );

    pinmux_router u_rte (
        .claim     (claim),
        .pin_in    (pin_in),
        .link_rx   (link_rx),
        .p1_rdata  (p1_rdata),
        .p4_rdata  (p4_rdata),
        .p8_rdata  (p8_rdata),
        .p16_rdata (p16_rdata),
        .p32_rdata (p32_rdata)
    );

endmodule

// File: rtl/shared_pin_mux_chk.sv
module shared_pin_mux_chk
    import pinmux_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  link_en,
    input logic                  link_wide,
    input logic [LINK_LANES-1:0] link_tx,
    input logic [LINK_LANES-1:0] link_rx,
    input logic [PIN_COUNT-1:0]  p4_rdata,
    input logic [PIN_COUNT-1:0]  p8_rdata,
    input logic [PIN_COUNT-1:0]  p16_rdata,
    input logic [PIN_COUNT-1:0]  p32_rdata,
    input logic [PIN_COUNT-1:0]  pin_oe,
    input logic [PIN_COUNT-1:0]  pin_out,
    input mux_cfg_t              cfg_q
);

    localparam int OUT_BASE = LINK_BASE + LINK_LANES;

    assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pin_oe == '0));

    assert_enable_latency_R2: assert property (@(posedge clk) disable iff (rst)
        (link_en && link_wide) |=> (pin_oe[OUT_BASE +: LINK_LANES] == '1));

    assert_link_drive_R3: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.link_en && cfg_q.link_wide) |-> (pin_out[OUT_BASE +: LINK_LANES] == link_tx));

    assert_narrow_lanes_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.link_en && !cfg_q.link_wide) |-> (link_rx[LINK_LANES-1:LINK_NARROW] == '0));

    assert_no_read_of_driven_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> (((p4_rdata | p8_rdata | p16_rdata | p32_rdata) & pin_oe) == '0));

    assert_undriven_low_R9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> ((pin_out & ~pin_oe) == '0));

endmodule

bind shared_pin_mux shared_pin_mux_chk u_chk (.*);

// File: tb/tb_shared_pin_mux.sv
`timescale 1ns/1ps
module tb_shared_pin_mux;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        link_en = 1'b0, link_wide = 1'b0;
    logic [4:0]  link_tx = '0, link_rx;
    logic [7:0]  p1_en = '0, p1_dir = '0, p1_wdata = '0, p1_rdata;
    logic [7:0]  p4_en = '0, p4_dir = '0;
    logic [31:0] p4_wdata = '0, p4_rdata;
    logic [3:0]  p8_en = '0, p8_dir = '0;
    logic [31:0] p8_wdata = '0, p8_rdata;
    logic [1:0]  p16_en = '0, p16_dir = '0;
    logic [31:0] p16_wdata = '0, p16_rdata;
    logic        p32_en = 1'b0, p32_dir = 1'b0;
    logic [31:0] p32_wdata = '0, p32_rdata;
    logic [31:0] pin_in = '0, pin_oe, pin_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    shared_pin_mux dut (.*);

    typedef struct packed {
        logic       le, lw;
        logic [7:0] e1, m1, e4, m4;
        logic [3:0] e8, m8;
        logic [1:0] e16, m16;
        logic       e32, m32;
        logic [31:0] oe, out, r32;
    } vec_t;

    // Pin inputs all ones, link_tx all ones, 32-bit write data all ones, other write data zero.
    localparam vec_t VECS [11] = '{
        '{1'b0,1'b0,8'h00,8'h00,8'h00,8'h00,4'h0,4'h0,2'b00,2'b00,1'b0,1'b0,32'h00000000,32'h00000000,32'h00000000},
        '{1'b0,1'b0,8'h00,8'h00,8'h00,8'h00,4'h0,4'h0,2'b00,2'b00,1'b1,1'b1,32'hFFFFFFFF,32'hFFFFFFFF,32'h00000000},
        '{1'b0,1'b0,8'h00,8'h00,8'h00,8'h00,4'h0,4'h0,2'b00,2'b00,1'b1,1'b0,32'h00000000,32'h00000000,32'hFFFFFFFF},
        '{1'b0,1'b0,8'h00,8'h00,8'h00,8'h00,4'h0,4'h0,2'b01,2'b01,1'b1,1'b1,32'hFFFFFFFF,32'hFFFF0000,32'h00000000},
        '{1'b0,1'b0,8'h00,8'h00,8'h00,8'h00,4'h0,4'h0,2'b10,2'b10,1'b1,1'b0,32'hFFFF0000,32'h00000000,32'h0000FFFF},
        '{1'b0,1'b0,8'h00,8'h00,8'h00,8'h00,4'h4,4'h0,2'b00,2'b00,1'b1,1'b0,32'h00000000,32'h00000000,32'hFF00FFFF},
        '{1'b1,1'b1,8'h00,8'h00,8'h00,8'h00,4'h0,4'h0,2'b00,2'b00,1'b1,1'b1,32'hFFFFE0FF,32'hFFFFE0FF,32'h00000000},
        '{1'b1,1'b0,8'h00,8'h00,8'h00,8'h00,4'h0,4'h0,2'b00,2'b00,1'b1,1'b0,32'h00006000,32'h00006000,32'hFFFF9CFF},
        '{1'b0,1'b0,8'hFF,8'hFF,8'h00,8'h00,4'h0,4'h0,2'b00,2'b00,1'b1,1'b0,32'h11111111,32'h00000000,32'hEEEEEEEE},
        '{1'b0,1'b0,8'h02,8'h02,8'h02,8'h00,4'h0,4'h0,2'b00,2'b00,1'b1,1'b1,32'hFFFFFF1F,32'hFFFFFF0F,32'h00000000},
        '{1'b1,1'b1,8'hFF,8'h00,8'h00,8'h00,4'h0,4'h0,2'b00,2'b00,1'b1,1'b0,32'h0003E000,32'h0003E000,32'hEEEC00EE}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input vec_t v);
        link_en = v.le;  link_wide = v.lw;
        p1_en = v.e1;    p1_dir = v.m1;
        p4_en = v.e4;    p4_dir = v.m4;
        p8_en = v.e8;    p8_dir = v.m8;
        p16_en = v.e16;  p16_dir = v.m16;
        p32_en = v.e32;  p32_dir = v.m32;
    endtask

    task automatic settle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_cfg();
        vec_t z;
        z = '0;
        set_cfg(z);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: nothing owned after reset
        chk("R1 pin_oe after reset", pin_oe, 32'h0);
        chk("R1 p32_rdata after reset", p32_rdata, 32'h0);
        chk("R1 p4_rdata after reset", p4_rdata, 32'h0);
        chk("R1 link_rx after reset", {27'h0, link_rx}, 32'h0);

        // Vector table: R3 R4 R5 R6 R8 R9
        pin_in = '1; link_tx = '1; p32_wdata = '1;
        p1_wdata = '0; p4_wdata = '0; p8_wdata = '0; p16_wdata = '0;
        for (int i = 0; i < 11; i++) begin
            set_cfg(VECS[i]);
            settle();
            chk($sformatf("R5 vec%0d pin_oe", i), pin_oe, VECS[i].oe);
            chk($sformatf("R9 vec%0d pin_out", i), pin_out, VECS[i].out);
            chk($sformatf("R6 vec%0d p32_rdata", i), p32_rdata, VECS[i].r32);
        end

        // R5: 1-bit ports lose pins 8,12,16 to the wide link (still in last vector)
        chk("R5 p1_rdata under wide link", {24'h0, p1_rdata}, 32'h000000E3);
        chk("R3 link_rx wide", {27'h0, link_rx}, 32'h0000001F);

        // R2: setting appears only after the next edge
        clear_cfg();
        settle();
        link_en = 1'b1; link_wide = 1'b1;
        #1;
        chk("R2 before edge pin_oe", pin_oe, 32'h0);
        settle();
        chk("R2 after edge pin_oe", pin_oe, 32'h0003E000);

        // R3: output lanes follow link_tx
        link_tx = 5'b01001;
        #1;
        chk("R3 link out lanes", pin_out, 32'h00012000);

        // R4: narrow link with a 4-bit output port on pins 12..15
        link_wide = 1'b0; p4_en = 8'h08; p4_dir = 8'h08; p4_wdata = '1;
        settle();
        chk("R4 narrow pin_oe", pin_oe, 32'h0000F000);
        chk("R4 narrow pin_out", pin_out, 32'h0000B000);
        chk("R4 narrow link_rx", {27'h0, link_rx}, 32'h00000003);

        // R7: writes to lost bits do not reach pins
        clear_cfg(); p4_wdata = '0;
        p32_en = 1'b1; p32_dir = 1'b1; p16_en = 2'b01; p16_dir = 2'b01;
        p16_wdata = '0; p32_wdata = 32'h0000FFFF;
        settle();
        chk("R7 lost write bits", pin_out, 32'h00000000);
        chk("R8 output port oe", pin_oe, 32'hFFFFFFFF);

        // R7: lost read bits are zero, winner reads the pins
        p32_dir = 1'b0; p16_dir = 2'b00; pin_in = 32'hA5A55A5A;
        settle();
        chk("R7 p32 lost read bits", p32_rdata, 32'hA5A50000);
        chk("R7 p16 read bits", p16_rdata, 32'h00005A5A);
        chk("R8 input ports oe", pin_oe, 32'h0);

        // R1: reset mid-run clears ownership
        p32_dir = 1'b1;
        settle();
        chk("R8 output port reads zero", p32_rdata, 32'h0);
        rst = 1'b1;
        settle();
        rst = 1'b0;
        chk("R1 reset mid-run pin_oe", pin_oe, 32'h0);
        chk("R1 reset mid-run p16_rdata", p16_rdata, 32'h0);

        done = 1'b1;
        finish_run();
    end

endmodule